// File: doc/BRIEF.md
# Idle-Locked Side-Stream Descrambler

This block takes a serial bit stream that was scrambled by adding a free-running key sequence, and recovers the plaintext. It receives zero, one or two bits per clock with a bit count. The line carries idle symbols, whose plaintext is all ones. This lets the receiver rebuild the key state directly from the line: while it is not locked, every received bit is inverted and shifted into the key register. Once enough consecutive bits decode as idle against that rebuilt key, the block declares lock.

While locked, the key register runs freely. Each received bit is XORed with the next key bit, and the plaintext comes out one register stage later with the same bit count. A cycle timer is reloaded every time a run of idle bits is seen. If the timer expires, the block drops lock and starts over. A test input shortens the timeout from hundreds of microseconds to a few microseconds, so that simulation stays short.

Top module: `idle_lock_descrambler`

## Requirements
- R1: After reset, `locked` is low, `out_valid` is 0 and `out_data` is 2'b11.
- R2: `in_valid` gives the number of bits this cycle (0, 1 or 2; the value 3 acts as 2). The first bit is `in_data[1]` and the second is `in_data[0]`. A cycle with count 0 advances neither the key nor any counter, and it produces `out_valid` 0 with `out_data` 2'b11.
- R3: The key sequence obeys k[n] = k[n-9] XOR k[n-11], and advances once per received bit. Ciphertext is the plaintext XOR the key, and while locked each output bit equals the transmitted plaintext bit.
- R4: While unlocked, each received bit is inverted and entered as the newest key bit. Lock rises at the clock edge that processes the bit completing 16 consecutive bits that decode as one, counted only after 11 bits have seeded the key. From reset with an idle line, this is the 27th received bit.
- R5: While unlocked, a bit that decodes as zero restarts the 16-bit run. Because that bit also corrupts the key history, an idle line after a single zero plaintext bit yields lock on the 27th bit following it.
- R6: Bits presented in a cycle where `locked` is high appear on the next cycle, with `out_valid` equal to the input count. The plaintext is in the same positions, and unused positions read 1.
- R7: Bits presented in a cycle where `locked` is low give `out_valid` 0 and `out_data` 2'b11 on the next cycle.
- R8: While locked, a cycle that completes or extends an idle run of at least 16 bits reloads the timer. `locked` falls exactly LIMIT clock cycles after the last reloading edge, where LIMIT = CLK_HZ*361/10^6 with `test_fast` low (18050 at the default 50 MHz). A line that stays idle keeps lock indefinitely.
- R9: With `test_fast` high at a reload, LIMIT = CLK_HZ*5/10^6 (250 at the default).
- R10: After lock falls, re-acquiring it requires a fresh 11 seed bits followed by 16 idle bits (27 bits on an idle line).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 2 | Received scrambled bits, first bit in bit 1 |
| in_valid | input | 2 | Number of valid received bits this cycle |
| test_fast | input | 1 | Selects the short unlock timeout |
| out_data | output | 2 | Descrambled bits, first bit in bit 1 |
| out_valid | output | 2 | Number of valid descrambled bits |
| locked | output | 1 | High while the key is synchronised |

## Verification
Some properties are checked on every clock:
- The output is forced invalid and to ones while unlocked.
- The output count follows the input count while locked.
- Lock never rises on a cycle without bits.
- Lock never falls while the timer is non-zero.
- The seed and run counters are cleared on the edge where lock drops.

Other behaviour can only be shown by the directed scenarios, which use a bench-side scrambler:
- The exact bit on which lock is acquired, for paired bits, single bits and after a corrupting zero bit.
- Correct plaintext under mixed bit counts.
- The exact cycle of both timeouts.

// File: rtl/idle_lock_descrambler.sv
module idle_lock_descrambler #(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned SLOW_US   = 361,
  parameter int unsigned FAST_US   = 5,
  parameter int unsigned KEY_W     = 11,
  parameter int unsigned TAP       = 9,
  parameter int unsigned SEED_BITS = 11,
  parameter int unsigned IDLE_RUN  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] in_data,
  input  logic [1:0] in_valid,
  input  logic       test_fast,
  output logic [1:0] out_data,
  output logic [1:0] out_valid,
  output logic       locked
);

  localparam longint SLOW_CYC = longint'(CLK_HZ) * longint'(SLOW_US) / 64'd1_000_000;
  localparam longint FAST_CYC = longint'(CLK_HZ) * longint'(FAST_US) / 64'd1_000_000;
  localparam int TMR_W  = $clog2(SLOW_CYC);
  localparam int SEED_W = $clog2(SEED_BITS + 1);
  localparam int RUN_W  = $clog2(IDLE_RUN + 1);
  localparam logic [TMR_W-1:0]  RELOAD_SLOW = TMR_W'(SLOW_CYC - 1);
  localparam logic [TMR_W-1:0]  RELOAD_FAST = TMR_W'(FAST_CYC - 1);
  localparam logic [SEED_W-1:0] SEED_FULL   = SEED_W'(SEED_BITS);
  localparam logic [RUN_W-1:0]  RUN_FULL    = RUN_W'(IDLE_RUN);

  logic [KEY_W-1:0]  key_q, key_n;
  logic [SEED_W-1:0] seed_q, seed_n;
  logic [RUN_W-1:0]  run_q, run_n;
  logic [TMR_W-1:0]  tmr_q;
  logic              locked_q;
  logic              hit;
  logic [1:0]        plain;
  logic [1:0]        vcnt;
  logic [TMR_W-1:0]  reload;

  assign vcnt   = in_valid[1] ? 2'd2 : in_valid;
  assign reload = test_fast ? RELOAD_FAST : RELOAD_SLOW;
  assign locked = locked_q;

  always_comb begin
    logic c, pred, p, idle;
    key_n  = key_q;
    seed_n = seed_q;
    run_n  = run_q;
    hit    = 1'b0;
    plain  = 2'b11;
    c = 1'b0; pred = 1'b0; p = 1'b0; idle = 1'b0;
    for (int i = 0; i < 2; i++) begin
      if (2'(i) < vcnt) begin
        c    = in_data[1-i];
        pred = key_n[TAP-1] ^ key_n[KEY_W-1];
        p    = c ^ pred;
        idle = (seed_n == SEED_FULL) && p;
        if (idle) run_n = (run_n == RUN_FULL) ? run_n : run_n + 1'b1;
        else      run_n = '0;
        if (idle && run_n == RUN_FULL) hit = 1'b1;
        if (seed_n != SEED_FULL) seed_n = seed_n + 1'b1;
        key_n = {key_n[KEY_W-2:0], locked_q ? pred : ~c};
        plain[1-i] = p;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q     <= '0;
      seed_q    <= '0;
      run_q     <= '0;
      tmr_q     <= '0;
      locked_q  <= 1'b0;
      out_valid <= 2'd0;
      out_data  <= 2'b11;
    end else begin
      key_q     <= key_n;
      out_valid <= locked_q ? vcnt : 2'd0;
      out_data  <= locked_q ? plain : 2'b11;
      if (!locked_q) begin
        seed_q <= seed_n;
        run_q  <= run_n;
        if (hit) begin
          locked_q <= 1'b1;
          tmr_q    <= reload;
        end
      end else if (hit) begin
        seed_q <= seed_n;
        run_q  <= run_n;
        tmr_q  <= reload;
      end else if (tmr_q == '0) begin
        locked_q <= 1'b0;
        seed_q   <= '0;
        run_q    <= '0;
      end else begin
        seed_q <= seed_n;
        run_q  <= run_n;
        tmr_q  <= tmr_q - 1'b1;
      end
    end
  end

  AST_UNLOCKED_OUT_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_q |=> (out_valid == 2'd0 && out_data == 2'b11)); // R7
  AST_COUNT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && in_valid != 2'd3) |=> out_valid == $past(in_valid)); // R6
  AST_NO_LOCK_WITHOUT_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked_q && in_valid == 2'd0) |=> !locked_q); // R4
  AST_HOLD_WHILE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && tmr_q != '0) |=> locked_q); // R8
  AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |-> tmr_q <= RELOAD_SLOW); // R9
  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked_q) |-> (seed_q == '0 && run_q == '0)); // R10

endmodule

// File: tb/test_idle_lock_descrambler.sv
module test_idle_lock_descrambler;
  localparam int CLK_PERIOD = 10;
  localparam int LIM_SLOW = 18050;
  localparam int LIM_FAST = 250;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] in_data = 2'b00;
  logic [1:0] in_valid = 2'd0;
  logic test_fast = 1'b0;
  logic [1:0] out_data, out_valid;
  logic locked;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [10:0] kr = 11'h5A3;

  always #(CLK_PERIOD/2) clk = ~clk;

  idle_lock_descrambler i_idle_lock_descrambler (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .test_fast(test_fast), .out_data(out_data), .out_valid(out_valid),
    .locked(locked));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic keybit(output bit k);
    k = kr[8] ^ kr[10];
    kr = {kr[9:0], k};
  endtask

  task automatic step(input int cnt, input bit pa, input bit pb);
    bit k, ca, cb;
    ca = 1'b1; cb = 1'b1;
    if (cnt >= 1) begin keybit(k); ca = pa ^ k; end
    if (cnt >= 2) begin keybit(k); cb = pb ^ k; end
    in_data = {ca, cb};
    in_valid = 2'(cnt);
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    chk("R1 locked", int'(locked), 0);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 out_data", int'(out_data), 3);
  endtask

  task automatic t_lock_pairs;
    for (int i = 1; i <= 14; i++) begin
      step(2, 1, 1);
      if (i == 13) chk("R4 not yet locked at 26 bits", int'(locked), 0);
      if (i == 14) begin
        chk("R4 locked at 27th bit", int'(locked), 1);
        chk("R7 unlocked input gives no output", int'(out_valid), 0);
        chk("R7 unlocked data ones", int'(out_data), 3);
      end
    end
  endtask

  task automatic t_data;
    for (int i = 0; i < 40; i++) begin
      int cnt;
      bit pa, pb;
      int exp;
      cnt = i % 3;
      pa = 1'($urandom);
      pb = 1'($urandom);
      exp = (cnt == 2) ? {pa, pb} : (cnt == 1) ? {pa, 1'b1} : 3;
      step(cnt, pa, pb);
      chk("R6 count follows input", int'(out_valid), cnt);
      chk("R3 plaintext recovered", int'(out_data), exp);
    end
  endtask

  task automatic t_fast_timeout;
    test_fast = 1'b1;
    for (int i = 0; i < 8; i++) step(2, 1, 1);
    for (int j = 1; j <= LIM_FAST; j++) begin
      step(2, 0, 0);
      if (j == 1) chk("R3 zero plaintext", int'(out_data), 0);
      if (j == LIM_FAST - 1) chk("R9 still locked", int'(locked), 1);
      if (j == LIM_FAST) chk("R9 fast timeout", int'(locked), 0);
    end
  endtask

  task automatic t_relock_keepalive;
    for (int i = 1; i <= 27; i++) begin
      step(1, 1, 1);
      if (i == 26) chk("R10 no relock at 26 bits", int'(locked), 0);
      if (i == 27) chk("R10 relock at 27th bit", int'(locked), 1);
    end
    for (int i = 0; i < 3 * LIM_FAST; i++) step(2, 1, 1);
    chk("R8 idle line keeps lock", int'(locked), 1);
  endtask

  task automatic t_slow_timeout;
    test_fast = 1'b0;
    for (int i = 0; i < 8; i++) step(2, 1, 1);
    for (int j = 1; j <= LIM_SLOW; j++) begin
      step(2, 0, 0);
      if (j == LIM_SLOW - 1) chk("R8 still locked", int'(locked), 1);
      if (j == LIM_SLOW) chk("R8 slow timeout", int'(locked), 0);
    end
  endtask

  task automatic t_run_break;
    for (int b = 1; b <= 48; b++) begin
      step(1, (b == 21) ? 1'b0 : 1'b1, 1'b1);
      if (b == 1) chk("R7 output forced after drop", int'(out_valid), 0);
      if (b == 47) chk("R5 no lock before 27 bits after zero", int'(locked), 0);
      if (b == 48) chk("R5 lock 27 bits after zero", int'(locked), 1);
    end
  endtask

  task automatic t_zero_count;
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 0);
      chk("R2 zero count output invalid", int'(out_valid), 0);
      chk("R2 zero count data ones", int'(out_data), 3);
    end
    step(2, 1, 0);
    chk("R2 key held over empty cycles", int'(out_data), 2);
    step(2, 0, 1);
    chk("R2 key held over empty cycles second", int'(out_data), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_lock_pairs();
    t_data();
    t_fast_timeout();
    t_relock_keepalive();
    t_slow_timeout();
    t_run_break();
    t_zero_count();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule